// File: doc/BRIEF.md
# Edge-Interval Window Checker

This block screens the demodulated bit stream of a receiver during its preamble. After a start pulse it waits out a warm-up period of a fixed number of timing ticks, because the demodulator output is not yet meaningful then. It then measures, in ticks, the time between successive transitions of the data bit. Each measured interval must fall inside a window set by a programmable lower bound and upper bound.

An interval that is too short fails when its closing edge arrives. An interval that grows to the upper bound fails on that very tick, without waiting for an edge. When a programmed number of consecutive intervals have been accepted, the block reports success. Either outcome is a single-cycle flag, and the block then returns to idle until the next start pulse. A receive controller uses the result to decide whether to go on to data recovery or to go back to polling.

Top module: `edge_window_checker`

## Requirements
- R1: After reset, `pass`, `fail` and `busy` are all low and the block is idle.
- R2: A `start` pulse sets `busy` in the next cycle and begins the warm-up from scratch, from any state. Accepted intervals counted before the pulse are discarded.
- R3: For the first WARMUP_TICKS ticks after `start`, data transitions are ignored and no result is produced.
- R4: An edge is a difference between the synchronized data bit and its value at the previous tick. Rising and falling transitions count alike. A pulse that begins and ends between two ticks is no edge.
- R5: The first edge after the warm-up only opens the first interval and is never judged.
- R6: The length L of an interval is the number of ticks from the tick of its opening edge to the tick of its closing edge. A closing edge with L < `lim_lo` fails.
- R7: When the interval reaches `lim_hi` ticks, the check fails on that tick, whether or not an edge arrives on it. A `lim_hi` of 0 fails on the first tick.
- R8: A closing edge with `lim_lo` <= L <= `lim_hi` − 1 is accepted, and the same edge opens the next interval.
- R9: `pass` is raised when the number of consecutive accepted intervals reaches `need_cnt`. A `need_cnt` of 0 acts as 1.
- R10: `pass` and `fail` are one-cycle pulses and never high together. Each appears in the clock cycle after the deciding tick, and `busy` falls in the same cycle.
- R11: If `lim_lo` >= `lim_hi`, the first measured interval fails.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timing tick enable; intervals are counted in these |
| rx_bit | input | 1 | Demodulated data bit, asynchronous to clk |
| start | input | 1 | One-cycle pulse that starts a check |
| lim_lo | input | LIM_W | Shortest accepted interval in ticks |
| lim_hi | input | LIM_W | Interval length in ticks that fails |
| need_cnt | input | NEED_W | Consecutive accepted intervals needed for success |
| pass | output | 1 | One-cycle success pulse |
| fail | output | 1 | One-cycle failure pulse |
| busy | output | 1 | High from start until a result |

## Verification
The bench builds the block with WARMUP_TICKS = 4, two synchronizer stages, 6-bit limits and a 4-bit required count. The short warm-up makes each trial cheap enough for a full sweep of every lower bound from 0 to 9, every upper bound from 0 to 10 and every interval length from 1 to 11, each outcome and its tick computed arithmetically. That sweep covers the too-short, timeout, inverted-window and accept branches at every boundary. Directed runs add the upper-limit extremes 62/63, multi-interval counts, a zero count, an inter-tick glitch and a restart in mid-check.

// File: rtl/ewc_pkg.sv
package ewc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WARM = 2'd1,
    ST_ARM  = 2'd2,
    ST_MEAS = 2'd3
  } ewc_state_t;
endpackage

// File: rtl/ewc_edge_detect.sv
// Synchronizes the data bit and flags a transition between consecutive ticks (R4).
module ewc_edge_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic din,
  output logic edge_hit
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q[0] <= din;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      if (tick) prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign edge_hit = tick & (sync_q[SYNC_STAGES-1] ^ prev_q);
endmodule

// File: rtl/ewc_warmup_timer.sv
// Counts warm-up ticks; done on the last one (R3).
module ewc_warmup_timer #(
  parameter int TICKS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic run,
  output logic done
);
  localparam int W = (TICKS < 2) ? 1 : $clog2(TICKS);
  localparam logic [W-1:0] LAST = W'(TICKS - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (tick)   cnt_q <= cnt_q + 1'b1;
  end

  assign done = run & tick & (cnt_q == LAST);
endmodule

// File: rtl/ewc_interval_judge.sv
// Measures one interval in ticks and rules on it (R6, R7, R8, R11).
module ewc_interval_judge #(
  parameter int LIM_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             edge_hit,
  input  logic             run,
  input  logic [LIM_W-1:0] lim_lo,
  input  logic [LIM_W-1:0] lim_hi,
  output logic             accept,
  output logic             reject
);
  logic [LIM_W-1:0] cv_q;
  logic [LIM_W:0]   nxt;
  logic             too_long;
  logic             too_short;

  assign nxt       = {1'b0, cv_q} + 1'b1;
  assign too_long  = nxt >= {1'b0, lim_hi};
  assign too_short = nxt <  {1'b0, lim_lo};

  assign reject = run & tick & (too_long | (edge_hit & too_short));
  assign accept = run & tick & edge_hit & ~too_long & ~too_short;

  always_ff @(posedge clk) begin
    if (rst || !run)             cv_q <= '0;
    else if (edge_hit)           cv_q <= '0;
    else if (tick && !too_long)  cv_q <= nxt[LIM_W-1:0];
  end
endmodule

// File: rtl/edge_window_checker.sv
module edge_window_checker #(
  parameter int LIM_W        = 6,
  parameter int NEED_W       = 4,
  parameter int WARMUP_TICKS = 16,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              rx_bit,
  input  logic              start,
  input  logic [LIM_W-1:0]  lim_lo,
  input  logic [LIM_W-1:0]  lim_hi,
  input  logic [NEED_W-1:0] need_cnt,
  output logic              pass,
  output logic              fail,
  output logic              busy
);
  import ewc_pkg::*;

  ewc_state_t        state_q;
  logic [NEED_W-1:0] good_q;
  logic [NEED_W:0]   good_nxt;
  logic [NEED_W:0]   need_eff;
  logic              edge_hit, warm_run, warm_done, meas_run, accept, reject;

  assign warm_run = (state_q == ST_WARM) & ~start;
  assign meas_run = (state_q == ST_MEAS) & ~start;
  assign good_nxt = {1'b0, good_q} + 1'b1;
  assign need_eff = (need_cnt == '0) ? (NEED_W+1)'(1) : {1'b0, need_cnt};

  ewc_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .tick(tick), .din(rx_bit), .edge_hit(edge_hit)
  );

  ewc_warmup_timer #(.TICKS(WARMUP_TICKS)) u_warm (
    .clk(clk), .rst(rst), .tick(tick), .run(warm_run), .done(warm_done)
  );

  ewc_interval_judge #(.LIM_W(LIM_W)) u_judge (
    .clk(clk), .rst(rst), .tick(tick), .edge_hit(edge_hit), .run(meas_run),
    .lim_lo(lim_lo), .lim_hi(lim_hi), .accept(accept), .reject(reject)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      good_q  <= '0;
      pass    <= 1'b0;
      fail    <= 1'b0;
      busy    <= 1'b0;
    end else begin
      pass <= 1'b0;
      fail <= 1'b0;
      if (start) begin
        state_q <= ST_WARM;
        good_q  <= '0;
        busy    <= 1'b1;
      end else begin
        case (state_q)
          ST_WARM: if (warm_done) state_q <= ST_ARM;
          ST_ARM:  if (edge_hit)  state_q <= ST_MEAS;
          ST_MEAS: begin
            if (reject) begin
              fail    <= 1'b1;
              busy    <= 1'b0;
              state_q <= ST_IDLE;
            end else if (accept) begin
              if (good_nxt >= need_eff) begin
                pass    <= 1'b1;
                busy    <= 1'b0;
                state_q <= ST_IDLE;
              end else begin
                good_q <= good_nxt[NEED_W-1:0];
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ewc_checker.sv
module ewc_checker (
  input logic clk,
  input logic rst,
  input logic tick,
  input logic start,
  input logic pass,
  input logic fail,
  input logic busy
);
  a_r10_exclusive: assert property (@(posedge clk) disable iff (rst) !(pass && fail));
  a_r10_pass_pulse: assert property (@(posedge clk) disable iff (rst) pass |=> !pass);
  a_r10_fail_pulse: assert property (@(posedge clk) disable iff (rst) fail |=> !fail);
  a_r10_idle_on_result: assert property (@(posedge clk) disable iff (rst) (pass || fail) |-> !busy);
  a_r10_after_tick: assert property (@(posedge clk) disable iff (rst) (pass || fail) |-> $past(tick));
  a_r2_start_busy: assert property (@(posedge clk) disable iff (rst) start |=> busy);
  a_r3_no_early_result: assert property (@(posedge clk) disable iff (rst) start |=> !(pass || fail));
endmodule

bind edge_window_checker ewc_checker u_chk (.*);

// File: tb/edge_window_checker_test.sv
`timescale 1ns/1ps
module edge_window_checker_test;
  localparam int LW = 6, NW = 4, WT = 4;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, rx_bit = 1'b0, start = 1'b0;
  logic [LW-1:0] lim_lo = '0, lim_hi = '0;
  logic [NW-1:0] need_cnt = 4'd1;
  logic pass, fail, busy;
  int total = 0, bad = 0;

  edge_window_checker #(.LIM_W(LW), .NEED_W(NW), .WARMUP_TICKS(WT), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .tick(tick), .rx_bit(rx_bit), .start(start),
    .lim_lo(lim_lo), .lim_hi(lim_hi), .need_cnt(need_cnt),
    .pass(pass), .fail(fail), .busy(busy)
  );

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // result code: 0 none, 1 pass, 2 fail
  task automatic tick_once(output int res);
    repeat (2) @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    res = pass ? 1 : (fail ? 2 : 0);
  endtask

  task automatic do_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(busy == 1'b1, "R2 busy after start", busy, 1);
  endtask

  task automatic warmup();
    int r;
    for (int i = 0; i < WT; i++) begin
      rx_bit = ~rx_bit;
      tick_once(r);
      check(r == 0, "R3 edge during warm-up", r, 0);
    end
    tick_once(r);
    rx_bit = ~rx_bit;
    tick_once(r);
    check(r == 0, "R5 opening edge judged", r, 0);
  endtask

  task automatic run_interval(input int len, output int res, output int at);
    int r;
    res = 0; at = len;
    for (int i = 1; i <= len; i++) begin
      if (i == len) rx_bit = ~rx_bit;
      tick_once(r);
      if (r != 0) begin
        res = r; at = i;
        break;
      end
    end
  endtask

  // expected: 0 accepted, 2 fail, plus tick index
  function automatic void expect_iv(input int lo, input int hi, input int len,
                                    output int res, output int at);
    int t0 = (hi == 0) ? 1 : hi;
    if (t0 <= len) begin res = 2; at = t0; end
    else if (len < lo) begin res = 2; at = len; end
    else begin res = 0; at = len; end
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int res, at, eres, eat;
    string tag;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(pass == 0 && fail == 0 && busy == 0, "R1 reset outputs", {pass, fail, busy}, 0);

    // Sweep: single interval, need 1 -> pass on accept
    need_cnt = 4'd1;
    for (int lo = 0; lo <= 9; lo++) begin
      for (int hi = 0; hi <= 10; hi++) begin
        for (int len = 1; len <= 11; len++) begin
          lim_lo = LW'(lo); lim_hi = LW'(hi);
          do_start();
          warmup();
          run_interval(len, res, at);
          expect_iv(lo, hi, len, eres, eat);
          if (eres == 0) eres = 1;
          if (eres == 2 && lo >= hi) tag = "R11 inverted window";
          else if (eres == 2 && at == ((hi == 0) ? 1 : hi)) tag = "R7 upper limit";
          else if (eres == 2) tag = "R6 short interval";
          else tag = "R8 accepted interval";
          check(res == eres && at == eat, tag, res * 100 + at, eres * 100 + eat);
          check(busy == 1'b0, "R10 busy after result", busy, 0);
        end
      end
    end

    // R8 / R7 / R6 at the top of the range
    lim_lo = 6'd10; lim_hi = 6'd63; need_cnt = 4'd2;
    do_start(); warmup();
    run_interval(62, res, at);
    check(res == 0, "R8 interval 62 accepted", res, 0);
    run_interval(10, res, at);
    check(res == 1 && at == 10, "R8 interval 10 then pass", res * 100 + at, 110);
    need_cnt = 4'd1;
    do_start(); warmup();
    run_interval(63, res, at);
    check(res == 2 && at == 63, "R7 reaches 63", res * 100 + at, 263);
    do_start(); warmup();
    run_interval(9, res, at);
    check(res == 2 && at == 9, "R6 interval 9 below 10", res * 100 + at, 209);

    // R9 consecutive count
    lim_lo = 6'd5; lim_hi = 6'd8; need_cnt = 4'd3;
    do_start(); warmup();
    run_interval(5, res, at);
    check(res == 0, "R9 first of three", res, 0);
    run_interval(7, res, at);
    check(res == 0, "R9 second of three", res, 0);
    run_interval(6, res, at);
    check(res == 1 && at == 6, "R9 third gives pass", res * 100 + at, 106);
    do_start(); warmup();
    run_interval(5, res, at);
    check(res == 0, "R9 first accepted", res, 0);
    run_interval(9, res, at);
    check(res == 2 && at == 8, "R7 second times out", res * 100 + at, 208);
    lim_lo = 6'd3; lim_hi = 6'd6; need_cnt = 4'd0;
    do_start(); warmup();
    run_interval(4, res, at);
    check(res == 1 && at == 4, "R9 zero count acts as one", res * 100 + at, 104);

    // R4 glitch between ticks is not an edge
    lim_lo = 6'd3; lim_hi = 6'd8; need_cnt = 4'd1;
    do_start(); warmup();
    tick_once(res);
    check(res == 0, "R4 first tick", res, 0);
    @(negedge clk) rx_bit = ~rx_bit;
    @(negedge clk) rx_bit = ~rx_bit;
    run_interval(4, res, at);
    check(res == 1 && at == 4, "R4 glitch ignored", res * 100 + at, 104);

    // R2 restart discards progress
    lim_lo = 6'd3; lim_hi = 6'd6; need_cnt = 4'd2;
    do_start(); warmup();
    run_interval(4, res, at);
    check(res == 0, "R2 before restart", res, 0);
    do_start(); warmup();
    run_interval(4, res, at);
    check(res == 0, "R2 progress discarded", res, 0);
    run_interval(4, res, at);
    check(res == 1 && at == 4, "R2 pass after fresh pair", res * 100 + at, 104);
    check(busy == 1'b0, "R10 idle after pass", busy, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule